// File: doc/BRIEF.md
# Overlapped Vector and Float Register File

This block holds thirty-two architectural registers, each one a single 256-bit physical entry. The same entries are reachable through three nested widths. A 64-bit view serves scalar floating-point code. A 128-bit view serves short vectors. A 256-bit view serves long vectors. All three views are indexed by the same 5-bit register number, so register n in the narrower views is simply the low part of entry n.

There are two combinational read ports and one write port, and each port carries its own 2-bit view selector. A narrow write merges into the wide entry and leaves the bits above its slice unchanged. A narrow read returns only its slice, zero-extended on the 256-bit output bus.

A read that names the register being written in the same cycle sees the merged value that the write will leave behind. This lets an execution pipeline read a result in the cycle it is produced. All entries clear on a synchronous reset.

Top module: `vrf_overlap`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears every one of the 32 entries to zero, and after reset every register reads zero through every view.
- R2: A write with view 2'b10 (256-bit) replaces all 256 bits of the addressed entry. A later 256-bit read of that register returns the written data.
- R3: A write with view 2'b01 (128-bit) updates bits 127:0 of the entry and leaves bits 255:128 unchanged.
- R4: A write with view 2'b00 (64-bit) updates bits 63:0 of the entry and leaves bits 255:64 unchanged.
- R5: A read with view 2'b00 returns entry bits 63:0 with output bits 255:64 at zero. A read with view 2'b01 returns entry bits 127:0 with output bits 255:128 at zero.
- R6: The three views share storage. After a 256-bit write to register n, the 128-bit read of n equals the low 128 bits of that data, and the 64-bit read of n equals the low 64 bits.
- R7: A write whose view is 2'b11 changes no entry. A cycle with wr_en low changes no entry, whatever the other write inputs hold.
- R8: A read with view 2'b11 returns all zeros.
- R9: When a read port and an active write name the same register in one cycle, the read returns the post-write merged entry, masked to the read's view.
- R10: The two read ports operate independently, each with its own register number and view, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_view | input | 2 | Write view: 00 64-bit, 01 128-bit, 10 256-bit, 11 illegal |
| wr_idx | input | 5 | Register number written |
| wr_data | input | 256 | Write data; only the slice the view selects is used |
| rd0_view | input | 2 | Read port 0 view selector |
| rd0_idx | input | 5 | Read port 0 register number |
| rd0_data | output | 256 | Read port 0 data, zero-extended slice |
| rd1_view | input | 2 | Read port 1 view selector |
| rd1_idx | input | 5 | Read port 1 register number |
| rd1_data | output | 256 | Read port 1 data, zero-extended slice |

## Verification
The read ports are combinational, so any corrupted entry is visible on the next read of that register through a view that covers the damaged bits. That read can come as soon as the cycle after the faulty write, or in the same cycle through the bypass path.

Some faults hide at the narrow views. A merge that clobbers upper bits, or an illegal view that is not blocked, only shows up when the register is read back at 256 bits. The sweeps therefore read every register at full width after each kind of narrow or suppressed write.

A broken bypass shows up as stale data in the write cycle itself.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
   typedef enum logic [1:0] {
      VIEW_SCALAR = 2'b00,
      VIEW_SHORT  = 2'b01,
      VIEW_LONG   = 2'b10,
      VIEW_BAD    = 2'b11
   } view_e;
endpackage

// File: rtl/vrf_view_mask.sv
// Turns a view selector into a bit mask over the wide entry.
module vrf_view_mask #(
   parameter int WIDE   = 256,
   parameter int MID    = 128,
   parameter int NARROW = 64
) (
   input  logic [1:0]      view,
   output logic [WIDE-1:0] mask
);
   import vrf_pkg::*;

   localparam logic [WIDE-1:0] M_NARROW = {{(WIDE-NARROW){1'b0}}, {NARROW{1'b1}}};
   localparam logic [WIDE-1:0] M_MID    = {{(WIDE-MID){1'b0}}, {MID{1'b1}}};
   localparam logic [WIDE-1:0] M_WIDE   = {WIDE{1'b1}};

   always_comb begin
      unique case (view_e'(view))
         VIEW_SCALAR: mask = M_NARROW;
         VIEW_SHORT:  mask = M_MID;
         VIEW_LONG:   mask = M_WIDE;
         default:     mask = '0;
      endcase
   end
endmodule

// File: rtl/vrf_write_merge.sv
// Merges the write slice into the old entry and decides whether the write acts.
module vrf_write_merge #(
   parameter int WIDE   = 256,
   parameter int MID    = 128,
   parameter int NARROW = 64
) (
   input  logic            wr_en,
   input  logic [1:0]      wr_view,
   input  logic [WIDE-1:0] old_entry,
   input  logic [WIDE-1:0] wr_data,
   output logic            wr_act,
   output logic [WIDE-1:0] merged
);
   logic [WIDE-1:0] wmask;

   vrf_view_mask #(.WIDE(WIDE), .MID(MID), .NARROW(NARROW)) u_mask (
      .view (wr_view),
      .mask (wmask)
   );

   assign wr_act = wr_en && (wr_view != 2'b11);
   assign merged = (old_entry & ~wmask) | (wr_data & wmask);
endmodule

// File: rtl/vrf_read_port.sv
// One read port: picks the stored entry or the bypassed write result,
// then masks it down to the requested view.
module vrf_read_port #(
   parameter int WIDE   = 256,
   parameter int MID    = 128,
   parameter int NARROW = 64,
   parameter int IDX_W  = 5
) (
   input  logic [1:0]       rd_view,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [WIDE-1:0]  stored,
   input  logic             wr_act,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WIDE-1:0]  merged,
   output logic [WIDE-1:0]  rd_data
);
   logic [WIDE-1:0] rmask;
   logic [WIDE-1:0] src;

   vrf_view_mask #(.WIDE(WIDE), .MID(MID), .NARROW(NARROW)) u_mask (
      .view (rd_view),
      .mask (rmask)
   );

   always_comb begin
      if (wr_act && (wr_idx == rd_idx)) src = merged;
      else                              src = stored;
      rd_data = src & rmask;
   end
endmodule

// File: rtl/vrf_overlap.sv
module vrf_overlap #(
   parameter int NREG   = 32,
   parameter int WIDE   = 256,
   parameter int MID    = 128,
   parameter int NARROW = 64,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [1:0]       wr_view,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WIDE-1:0]  wr_data,
   input  logic [1:0]       rd0_view,
   input  logic [IDX_W-1:0] rd0_idx,
   output logic [WIDE-1:0]  rd0_data,
   input  logic [1:0]       rd1_view,
   input  logic [IDX_W-1:0] rd1_idx,
   output logic [WIDE-1:0]  rd1_data
);
   generate
      if (!(NARROW > 0 && NARROW < MID && MID < WIDE))
         $error("vrf_overlap: view widths must nest strictly");
      if ((1 << IDX_W) != NREG)
         $error("vrf_overlap: NREG must be a power of two");
   endgenerate

   logic [WIDE-1:0] regs [NREG];
   logic            wr_act;
   logic [WIDE-1:0] merged;

   vrf_write_merge #(.WIDE(WIDE), .MID(MID), .NARROW(NARROW)) u_merge (
      .wr_en     (wr_en),
      .wr_view   (wr_view),
      .old_entry (regs[wr_idx]),
      .wr_data   (wr_data),
      .wr_act    (wr_act),
      .merged    (merged)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (wr_act) begin
         regs[wr_idx] <= merged;
      end
   end

   vrf_read_port #(.WIDE(WIDE), .MID(MID), .NARROW(NARROW), .IDX_W(IDX_W)) u_rd0 (
      .rd_view (rd0_view),
      .rd_idx  (rd0_idx),
      .stored  (regs[rd0_idx]),
      .wr_act  (wr_act),
      .wr_idx  (wr_idx),
      .merged  (merged),
      .rd_data (rd0_data)
   );

   vrf_read_port #(.WIDE(WIDE), .MID(MID), .NARROW(NARROW), .IDX_W(IDX_W)) u_rd1 (
      .rd_view (rd1_view),
      .rd_idx  (rd1_idx),
      .stored  (regs[rd1_idx]),
      .wr_act  (wr_act),
      .wr_idx  (wr_idx),
      .merged  (merged),
      .rd_data (rd1_data)
   );
endmodule

// File: rtl/vrf_overlap_chk.sv
module vrf_overlap_chk #(
   parameter int WIDE   = 256,
   parameter int MID    = 128,
   parameter int NARROW = 64,
   parameter int IDX_W  = 5
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic [1:0]       wr_view,
   input logic [IDX_W-1:0] wr_idx,
   input logic [WIDE-1:0]  wr_data,
   input logic [1:0]       rd0_view,
   input logic [IDX_W-1:0] rd0_idx,
   input logic [WIDE-1:0]  rd0_data,
   input logic [1:0]       rd1_view,
   input logic [IDX_W-1:0] rd1_idx,
   input logic [WIDE-1:0]  rd1_data
);
   logic hit0_now;
   assign hit0_now = wr_en && (wr_view != 2'b11) && (wr_idx == rd0_idx);

   assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !hit0_now) |-> (rd0_data == '0));

   assert_long_persist_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en) && $past(wr_view) == 2'b10 && rd0_view == 2'b10
       && rd0_idx == $past(wr_idx) && !hit0_now) |-> (rd0_data == $past(wr_data)));

   assert_scalar_keeps_upper_R4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en) && $past(wr_view) == 2'b00 && $past(rd0_view) == 2'b10
       && $past(rd0_idx) == $past(wr_idx) && rd0_view == 2'b10
       && rd0_idx == $past(rd0_idx) && !hit0_now)
      |-> (rd0_data[WIDE-1:NARROW] == $past(rd0_data[WIDE-1:NARROW])
           && rd0_data[NARROW-1:0] == $past(wr_data[NARROW-1:0])));

   assert_zero_ext_scalar_R5: assert property (@(posedge clk) disable iff (rst)
      (rd1_view == 2'b00) |-> (rd1_data[WIDE-1:NARROW] == '0));

   assert_zero_ext_short_R5: assert property (@(posedge clk) disable iff (rst)
      (rd0_view == 2'b01) |-> (rd0_data[WIDE-1:MID] == '0));

   assert_bad_read_R8: assert property (@(posedge clk) disable iff (rst)
      (rd1_view == 2'b11) |-> (rd1_data == '0));

   assert_bypass_long_R9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_view == 2'b10 && rd1_view == 2'b10 && rd1_idx == wr_idx)
      |-> (rd1_data == wr_data));
endmodule

bind vrf_overlap vrf_overlap_chk #(
   .WIDE(WIDE), .MID(MID), .NARROW(NARROW), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx),
   .wr_data(wr_data), .rd0_view(rd0_view), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
   .rd1_view(rd1_view), .rd1_idx(rd1_idx), .rd1_data(rd1_data)
);

// File: tb/tb_vrf_overlap.sv
module tb_vrf_overlap;
   localparam int W = 256;
   localparam int N = 32;

   logic         clk = 1'b0;
   logic         rst;
   logic         wr_en;
   logic [1:0]   wr_view;
   logic [4:0]   wr_idx;
   logic [W-1:0] wr_data;
   logic [1:0]   rd0_view, rd1_view;
   logic [4:0]   rd0_idx, rd1_idx;
   logic [W-1:0] rd0_data, rd1_data;

   logic [W-1:0] model [N];
   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   vrf_overlap dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd0_view(rd0_view), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
      .rd1_view(rd1_view), .rd1_idx(rd1_idx), .rd1_data(rd1_data)
   );

   function automatic logic [W-1:0] vmask(input logic [1:0] v);
      case (v)
         2'b00:   return {{(W-64){1'b0}}, {64{1'b1}}};
         2'b01:   return {{(W-128){1'b0}}, {128{1'b1}}};
         2'b10:   return {W{1'b1}};
         default: return '0;
      endcase
   endfunction

   function automatic logic [W-1:0] pat(input int i, input int s);
      logic [W-1:0] r;
      for (int k = 0; k < 8; k++)
         r[k*32 +: 32] = 32'h9E3779B9 * (i * 8 + k + 1 + s * 37) ^ (s << 20);
      return r;
   endfunction

   task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // One vector: drive at falling edge, check reads mid-low-phase, commit at rising edge.
   task automatic apply(input logic we, input logic [1:0] wv, input int wi, input logic [W-1:0] wd,
                        input logic [1:0] v0, input int i0, input logic [1:0] v1, input int i1,
                        input string tag);
      logic [W-1:0] post [N];
      wr_en = we; wr_view = wv; wr_idx = 5'(wi); wr_data = wd;
      rd0_view = v0; rd0_idx = 5'(i0); rd1_view = v1; rd1_idx = 5'(i1);
      post = model;
      if (we && wv != 2'b11)
         post[wi] = (model[wi] & ~vmask(wv)) | (wd & vmask(wv));
      #2;
      chk(rd0_data, post[i0] & vmask(v0), {tag, " port0"});
      chk(rd1_data, post[i1] & vmask(v1), {tag, " port1"});
      @(posedge clk);
      model = post;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) model[i] = '0;
      rst = 1'b1; wr_en = 1'b0; wr_view = 2'b10; wr_idx = '0; wr_data = '1;
      rd0_view = 2'b10; rd0_idx = '0; rd1_view = 2'b10; rd1_idx = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: all entries zero after reset, seen at full and narrow width
      for (int i = 0; i < N; i++)
         apply(1'b0, 2'b10, i, pat(i, 0), 2'b10, i, 2'b00, N - 1 - i, "R1");

      // R2 and R9: full-width writes, read in the same cycle through the bypass
      for (int i = 0; i < N; i++)
         apply(1'b1, 2'b10, i, pat(i, 1), 2'b10, i, 2'b01, i, "R2 R9");

      // R5, R6, R8, R10: every register through every view, ports on different registers
      for (int i = 0; i < N; i++)
         for (int v = 0; v < 4; v++)
            apply(1'b0, 2'b00, 0, '0, 2'(v), i, 2'(3 - v), (i + 5) % N, "R5 R6 R8 R10");

      // R4: 64-bit writes to even registers, then full-width read-back
      for (int i = 0; i < N; i += 2)
         apply(1'b1, 2'b00, i, pat(i, 2), 2'b10, i, 2'b00, i, "R4 R9");
      // R3: 128-bit writes to odd registers
      for (int i = 1; i < N; i += 2)
         apply(1'b1, 2'b01, i, pat(i, 3), 2'b00, i, 2'b10, i, "R3 R9");
      for (int i = 0; i < N; i++)
         apply(1'b0, 2'b10, 0, '0, 2'b10, i, 2'b01, i, "R3 R4 readback");

      // R7: illegal-view writes and disabled writes leave entries untouched
      for (int i = 0; i < N; i++)
         apply(1'b1, 2'b11, i, pat(i, 9), 2'b10, i, 2'b10, (i + 1) % N, "R7 badview");
      for (int i = 0; i < N; i++)
         apply(1'b0, 2'b10, i, pat(i, 10), 2'b10, i, 2'b11, i, "R7 disabled");
      for (int i = 0; i < N; i++)
         apply(1'b0, 2'b00, 0, '0, 2'b10, i, 2'b10, N - 1 - i, "R7 readback");

      // R9: narrow writes bypassed to the other port at full width
      for (int i = 0; i < N; i++)
         apply(1'b1, 2'(i % 2), i, pat(i, 11), 2'b00, i, 2'b10, i, "R9 narrow");

      // R1: reset again after data is present
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < N; i++) model[i] = '0;
      for (int i = 0; i < N; i++)
         apply(1'b0, 2'b10, 0, '0, 2'b10, i, 2'b01, i, "R1 rereset");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule